// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block holds the interrupt enable and pending state for a DMA controller with 8, 12 or 16 channels, and folds that state into one interrupt line. Each channel reports three kinds of event as single-cycle pulses: half of a package moved, a whole package finished, and the end of its queue reached. Each event sets a pending bit that stays set until software clears it. Each pending bit has its own enable bit. The interrupt line is high whenever an enabled bit is pending.

Software reaches the bank through a plain 32-bit register port. A write takes effect on the clock edge. A read returns the data combinationally from the address. Each channel owns a 4-bit group in an enable word and a 4-bit group in a pending word. Eight channels share one word, so two enable words and two pending words cover 16 channels.

An interrupt handler reads a pending word, writes the same value back to clear exactly the events it saw, and then services the channels.

Top module: `dma_irq_bank`

## Requirements
- R1: Enable word 0 is at byte address 0x00 and enable word 1 at 0x04. Channel n uses word n/8, bits (n mod 8)*4 up to (n mod 8)*4+2. A write loads those bits and a read returns them.
- R2: Pending word 0 is at 0x10 and pending word 1 at 0x14, with the same placement of channels. Within a channel group, bit 0 is the half-package event, bit 1 is the package-done event and bit 2 is the queue-end event.
- R3: An event pulse sets its pending bit on the next clock edge, whether or not that bit is enabled.
- R4: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing back a value just read clears exactly those bits. Writing all ones to both pending words clears everything.
- R5: An event that arrives in the same cycle as a software clear of its bit leaves the bit set.
- R6: The interrupt output is registered. It goes high one cycle after some pending bit has its enable bit set, and it goes low one cycle after no enabled bit is pending.
- R7: Bit 3 of every channel group is reserved: writes to it are ignored and it reads as zero.
- R8: Bits of channels at or above NUM_CH ignore writes and read as zero. With 8 channels, both second words read as zero.
- R9: After reset, all enable and pending bits are zero and the interrupt output is low.
- R10: A read from any address other than the four words returns zero, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| evt_half_i | input | NUM_CH | Half-package event pulse, one per channel |
| evt_pkg_i | input | NUM_CH | Package-done event pulse, one per channel |
| evt_queue_i | input | NUM_CH | Queue-end event pulse, one per channel |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The tests use the default configuration of 12 channels. Writing all ones to each enable word separates implemented bits from reserved bits and from bits of missing channels. A write with mixed digits shows whether the channel groups sit in the right nibbles.

Events are raised on channels in both words, on every event type, while enables are off. This shows the bit placement and shows that pending bits latch whether or not they are enabled. Partial clears, read-back clears and all-ones clears separate the write-one-to-clear behaviour from plain overwrite.

A clear and an event on the same bit in the same cycle checks which one wins. The interrupt line is sampled one cycle before and one cycle after each change, which fixes its latency in both directions.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W        = 32;
  localparam int GRP_W        = 4;   // bits reserved per channel
  localparam int EVT_W        = 3;   // implemented bits per channel
  localparam int CH_PER_WORD  = REG_W / GRP_W;
  localparam int MAX_CH       = 16;
  localparam int NUM_WORDS    = MAX_CH / CH_PER_WORD;
  localparam int EN_BASE      = 'h00;
  localparam int PEND_BASE    = 'h10;
  localparam int WORD_STRIDE  = 4;

  // event position inside a channel group
  localparam int EV_HALF  = 0;
  localparam int EV_PKG   = 1;
  localparam int EV_QUEUE = 2;
endpackage

// File: rtl/dma_irq_slot.sv
// Enable and pending state of one channel.
module dma_irq_slot
  import dma_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic [EVT_W-1:0] en_wdata_i,
  input  logic [EVT_W-1:0] pend_clr_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] en_q_o,
  output logic [EVT_W-1:0] pend_q_o
);
  logic [EVT_W-1:0] en_q, en_d;
  logic [EVT_W-1:0] pend_q, pend_d;
  logic             pend_ce;

  always_comb begin
    en_d    = en_wdata_i;
    // a new event takes priority over a clear in the same cycle
    pend_d  = (pend_q & ~pend_clr_i) | evt_i;
    pend_ce = (|pend_clr_i) | (|evt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i) en_q   <= en_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  assign en_q_o   = en_q;
  assign pend_q_o = pend_q;
endmodule

// File: rtl/dma_irq_rdmux.sv
// Read-data selection over the enable and pending words.
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_WORDS*REG_W-1:0] en_flat_i,
  input  logic [NUM_WORDS*REG_W-1:0] pend_flat_i,
  output logic [REG_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(EN_BASE + w * WORD_STRIDE))
        rdata_o = en_flat_i[w*REG_W +: REG_W];
      if (addr_i == ADDR_W'(PEND_BASE + w * WORD_STRIDE))
        rdata_o = pend_flat_i[w*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_CH-1:0] evt_half_i,
  input  logic [NUM_CH-1:0] evt_pkg_i,
  input  logic [NUM_CH-1:0] evt_queue_i,
  output logic              irq_o
);
  logic [NUM_WORDS-1:0]          en_wsel;
  logic [NUM_WORDS-1:0]          pend_wsel;
  logic [NUM_WORDS*REG_W-1:0]    en_flat;
  logic [NUM_WORDS*REG_W-1:0]    pend_flat;
  logic [EVT_W*NUM_CH-1:0]       en_all;
  logic [EVT_W*NUM_CH-1:0]       pend_all;
  logic                          irq_d, irq_q;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  // word select decode
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign en_wsel[w]   = reg_wr_i && (reg_addr_i == ADDR_W'(EN_BASE + w * WORD_STRIDE));
    assign pend_wsel[w] = reg_wr_i && (reg_addr_i == ADDR_W'(PEND_BASE + w * WORD_STRIDE));
  end

  // one lane per possible channel; lanes beyond NUM_CH read as zero
  for (genvar n = 0; n < MAX_CH; n++) begin : g_lane
    localparam int W = n / CH_PER_WORD;
    localparam int B = (n % CH_PER_WORD) * GRP_W;
    if (n < NUM_CH) begin : g_live
      logic [EVT_W-1:0] en_q, pend_q, clr, evt;
      assign evt = {evt_queue_i[n], evt_pkg_i[n], evt_half_i[n]};
      assign clr = pend_wsel[W] ? reg_wdata_i[B +: EVT_W] : '0;
      dma_irq_slot u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_we_i    (en_wsel[W]),
        .en_wdata_i (reg_wdata_i[B +: EVT_W]),
        .pend_clr_i (clr),
        .evt_i      (evt),
        .en_q_o     (en_q),
        .pend_q_o   (pend_q)
      );
      assign en_flat[W*REG_W + B +: GRP_W]   = {1'b0, en_q};
      assign pend_flat[W*REG_W + B +: GRP_W] = {1'b0, pend_q};
      assign en_all[n*EVT_W +: EVT_W]        = en_q;
      assign pend_all[n*EVT_W +: EVT_W]      = pend_q;
    end else begin : g_absent
      assign en_flat[W*REG_W + B +: GRP_W]   = '0;
      assign pend_flat[W*REG_W + B +: GRP_W] = '0;
    end
  end

  dma_irq_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr_i      (reg_addr_i),
    .en_flat_i   (en_flat),
    .pend_flat_i (pend_flat),
    .rdata_o     (reg_rdata_o)
  );

  always_comb begin
    irq_d = |(pend_all & en_all);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    reg_wr_i,
  input logic [ADDR_W-1:0]       reg_addr_i,
  input logic [REG_W-1:0]        reg_rdata_o,
  input logic [NUM_CH-1:0]       evt_half_i,
  input logic [NUM_CH-1:0]       evt_pkg_i,
  input logic [NUM_CH-1:0]       evt_queue_i,
  input logic                    irq_o,
  input logic [EVT_W*NUM_CH-1:0] en_all,
  input logic [EVT_W*NUM_CH-1:0] pend_all
);
  logic [EVT_W*NUM_CH-1:0] ev;
  logic pend_wr, en_wr;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ev
    assign ev[n*EVT_W +: EVT_W] = {evt_queue_i[n], evt_pkg_i[n], evt_half_i[n]};
  end

  assign pend_wr = reg_wr_i && (reg_addr_i == ADDR_W'(PEND_BASE) ||
                                reg_addr_i == ADDR_W'(PEND_BASE + WORD_STRIDE));
  assign en_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(EN_BASE) ||
                                reg_addr_i == ADDR_W'(EN_BASE + WORD_STRIDE));

  // R3 and R5: an event always lands in its pending bit
  assert_event_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((pend_all & $past(ev)) == $past(ev)));

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_all & en_all)) |=> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_all & en_all)) |=> !irq_o);

  assert_pend_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == '0 && !pend_wr) |=> $stable(pend_all));

  assert_en_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(en_all));

  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & 32'h8888_8888) == '0);
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .evt_half_i  (evt_half_i),
  .evt_pkg_i   (evt_pkg_i),
  .evt_queue_i (evt_queue_i),
  .irq_o       (irq_o),
  .en_all      (en_all),
  .pend_all    (pend_all)
);

// File: tb/dma_irq_bank_test.sv
module dma_irq_bank_test;
  localparam int NCH = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  e_half = '0, e_pkg = '0, e_queue = '0;
  logic            irq;
  int              n_run = 0, n_fail = 0;
  bit              done = 1'b0;

  always #2 clk = ~clk;

  dma_irq_bank #(.NUM_CH(NCH), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_half_i(e_half),
    .evt_pkg_i(e_pkg), .evt_queue_i(e_queue), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] h, input logic [NCH-1:0] p, input logic [NCH-1:0] q);
    @(negedge clk); e_half = h; e_pkg = p; e_queue = q;
    @(negedge clk); e_half = '0; e_pkg = '0; e_queue = '0;
  endtask

  task automatic t_reset();
    rd_chk("R9 en0", 8'h00, 0); rd_chk("R9 en1", 8'h04, 0);
    rd_chk("R9 pend0", 8'h10, 0); rd_chk("R9 pend1", 8'h14, 0);
    chk("R9 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enable_map();
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_chk("R1 R7 en0 all ones", 8'h00, 32'h7777_7777);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rd_chk("R8 en1 only ch8-11", 8'h04, 32'h0000_7777);
    wr_reg(8'h00, 32'h1234_5670);
    rd_chk("R1 en0 pattern", 8'h00, 32'h1234_5670);
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    rd_chk("R1 en0 masked", 8'h00, 0);
    rd_chk("R1 en1 masked", 8'h04, 0);
  endtask

  task automatic t_pending_latch();
    pulse('0, 12'h200, '0);                   // pkg event ch9
    rd_chk("R2 R3 pkg ch9 word1", 8'h14, 32'h0000_0020);
    pulse(12'h001, '0, 12'h080);              // half ch0, queue ch7
    rd_chk("R2 R3 half ch0 queue ch7", 8'h10, 32'h4000_0001);
    @(negedge clk);
    chk("R3 R6 no irq while disabled", {31'b0, irq}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr_reg(8'h10, 32'h0000_0001);
    rd_chk("R4 partial clear", 8'h10, 32'h4000_0000);
    rd_reg(8'h10, d);
    wr_reg(8'h10, d);
    rd_chk("R4 write back read value", 8'h10, 0);
    rd_chk("R4 other word untouched", 8'h14, 32'h0000_0020);
    pulse(12'hFFF, 12'hFFF, 12'hFFF);
    rd_chk("R8 all events word1", 8'h14, 32'h0000_7777);
    wr_reg(8'h10, 32'hFFFF_FFFF); wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_chk("R4 clear all w0", 8'h10, 0);
    rd_chk("R4 clear all w1", 8'h14, 0);
  endtask

  task automatic t_collision();
    pulse('0, 12'h008, '0);
    rd_chk("R2 pkg ch3", 8'h10, 32'h0000_2000);
    @(negedge clk); wr = 1'b1; addr = 8'h10; wdata = 32'h0000_2000; e_pkg = 12'h008;
    @(negedge clk); wr = 1'b0; wdata = '0; e_pkg = '0;
    rd_chk("R5 event beats clear", 8'h10, 32'h0000_2000);
    wr_reg(8'h10, 32'h0000_2000);
    rd_chk("R4 clear after collision", 8'h10, 0);
  endtask

  task automatic t_irq();
    wr_reg(8'h00, 32'h0000_0200);             // enable pkg ch2
    @(negedge clk); e_pkg = 12'h004;
    @(negedge clk); e_pkg = '0;
    chk("R6 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 irq high", {31'b0, irq}, 1);
    wr_reg(8'h10, 32'h0000_0200);
    chk("R6 irq still high", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R6 irq low after clear", {31'b0, irq}, 0);
    pulse(12'h004, '0, '0);                    // half ch2, not enabled
    @(negedge clk);
    chk("R6 disabled kind no irq", {31'b0, irq}, 0);
    wr_reg(8'h00, 32'h0000_0100);              // enable half ch2
    @(negedge clk);
    chk("R6 irq on late enable", {31'b0, irq}, 1);
    wr_reg(8'h00, 0);
    @(negedge clk);
    chk("R6 irq low after mask", {31'b0, irq}, 0);
    wr_reg(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    wr_reg(8'h00, 32'h0000_0007);
    pulse('0, 12'h001, '0);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_chk("R10 read 0x08", 8'h08, 0);
    rd_chk("R10 read 0x20", 8'h20, 0);
    rd_chk("R10 en kept", 8'h00, 32'h0000_0007);
    rd_chk("R10 pend kept", 8'h10, 32'h0000_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_map();
    t_pending_latch();
    t_w1c();
    t_collision();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule